// File: doc/BRIEF.md
# Thread Run-State Update Scheduler

This block sits next to a processor's control register file and decides, after software has changed that file, which hardware threads may keep running. Every masked software write to the register file raises a strobe. The first strobe arms a pending update, and the update runs a fixed number of cycles later. Strobes that arrive while the update is still pending are absorbed into it, so a burst of writes costs one sweep.

When the delay has elapsed, the scheduler walks the implemented threads in index order, one thread per cycle. For each thread it looks at two inputs: that thread's halt flag and its activated flag. It then fires exactly one of two one-cycle pulses for that thread. A halt request goes out if the thread is halted or not activated. A resume request goes out if the thread is not halted and is activated. A one-cycle done pulse closes the sweep, and in that cycle the pending update is released.

The number of threads visited comes from a configuration count field holding "threads minus one". It is clamped to the number of thread slots that were built.

The control is a four-state machine:
- `ST_IDLE`: nothing is pending.
- `ST_WAIT`: the delay is counting down.
- `ST_SWEEP`: one thread is decided per cycle.
- `ST_DONE`: the done pulse is driven.

Its transitions are:
- idle→wait on a strobe.
- wait→sweep when the delay expires.
- sweep→sweep while threads remain.
- sweep→done after the last thread.
- done→idle with no strobe.
- done→wait on a strobe.

Top module: `thread_runstate_sched`

## Requirements
- R1: After reset, and while no strobe has been seen, `halt_req`, `resume_req` and `sweep_done` are all zero.
- R2: A strobe sampled at clock edge E0 puts thread i's decision on the outputs in the cycle that follows edge E0+DELAY+i. Thread 0 is therefore visible DELAY cycles after the strobe edge.
- R3: While an update is pending, further strobes are ignored: they do not lengthen the delay, restart the sweep, or schedule a second sweep.
- R4: The sweep visits threads 0 to min(`cfg_count`, NUM_THREADS-1), one thread per cycle, where `cfg_count` holds the thread count minus one.
- R5: A visited thread receives a halt request when its `thr_halt` bit is 1 or its `thr_active` bit is 0.
- R6: A visited thread receives a resume request when its `thr_halt` bit is 0 and its `thr_active` bit is 1.
- R7: In each sweep, every visited thread receives exactly one one-cycle pulse, never both kinds. At most one thread is pulsed in any cycle.
- R8: `sweep_done` is high for exactly one cycle, immediately after the last visited thread's cycle. The pending update is released at the end of that cycle.
- R9: A strobe in the `sweep_done` cycle arms a new pending update, which sweeps again after a further DELAY cycles.
- R10: Threads beyond the visited range receive no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | One masked write to the control register file took place |
| thr_halt | input | NUM_THREADS | Per-thread halt flag |
| thr_active | input | NUM_THREADS | Per-thread activated flag |
| cfg_count | input | CNT_W | Implemented thread count minus one |
| halt_req | output | NUM_THREADS | Per-thread one-cycle halt request |
| resume_req | output | NUM_THREADS | Per-thread one-cycle resume request |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The assertions take for granted that `cfg_count`, `thr_halt` and `thr_active` stay stable from the strobe until the done pulse. The block samples these inputs live during the sweep, so changing them mid-sweep would make a thread's decision depend on which cycle it was visited in. The assertions also take for granted that the strobe is a synchronous level, sampled once per edge.

The stimulus respects both conditions. It sets the flags and the count before raising the strobe and holds them until the sweep window has closed. Extra strobes are placed only at chosen sample points: during the wait, during the sweep, or in the done cycle.

// File: rtl/thr_sched_pkg.sv
package thr_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SWEEP = 2'd2,
        ST_DONE  = 2'd3
    } sched_state_e;
endpackage

// File: rtl/thr_delay_timer.sv
module thr_delay_timer #(
    parameter int DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int DLY_W = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [DLY_W-1:0] RELOAD = DLY_W'(DELAY - 1);

    logic [DLY_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= RELOAD;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    // The countdown only ever moves downward while running and not reloaded.
    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !expired) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/thr_verdict.sv
module thr_verdict #(
    parameter int NUM_THREADS = 4,
    parameter int IDX_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [IDX_W-1:0]       idx,
    input  logic [NUM_THREADS-1:0] thr_halt,
    input  logic [NUM_THREADS-1:0] thr_active,
    output logic [NUM_THREADS-1:0] halt_req,
    output logic [NUM_THREADS-1:0] resume_req
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic picked;
        assign picked        = en && (idx == IDX_W'(t));
        assign halt_req[t]   = picked && (thr_halt[t] || !thr_active[t]);
        assign resume_req[t] = picked && !thr_halt[t] && thr_active[t];
    end

    assert_one_thread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_req | resume_req));
    assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req & resume_req) == '0);
    assert_visit_decides_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ($countones(halt_req | resume_req) == 1));
endmodule

// File: rtl/thr_sweep_fsm.sv
module thr_sweep_fsm
    import thr_sched_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_strobe,
    input  logic             expired,
    input  logic [IDX_W-1:0] last_idx,
    output logic             timer_load,
    output logic             timer_run,
    output logic             sweep_en,
    output logic [IDX_W-1:0] idx,
    output logic             sweep_done
);
    sched_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (wr_strobe) state_nx = ST_WAIT;
            ST_WAIT:  if (expired) state_nx = ST_SWEEP;
            ST_SWEEP: if (idx == last_idx) state_nx = ST_DONE;
            ST_DONE:  state_nx = wr_strobe ? ST_WAIT : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SWEEP && idx != last_idx) begin
                idx <= idx + 1'b1;
            end else begin
                idx <= '0;
            end
        end
    end

    always_comb begin
        timer_load = (state_nx == ST_WAIT) && (state != ST_WAIT);
        timer_run  = (state == ST_WAIT);
        sweep_en   = (state == ST_SWEEP);
        sweep_done = (state == ST_DONE);
    end

    assert_wait_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !expired) |=> (state == ST_WAIT));
    assert_strobe_absorbed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && wr_strobe) |=> (state == ST_SWEEP || state == ST_DONE));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);
    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_done && !wr_strobe) |=> (state == ST_IDLE));
    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_done && wr_strobe) |=> (state == ST_WAIT));
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_en |-> (idx <= last_idx));
endmodule

// File: rtl/thread_runstate_sched.sv
module thread_runstate_sched #(
    parameter int NUM_THREADS = 4,
    parameter int DELAY       = 1,
    parameter int CNT_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_strobe,
    input  logic [NUM_THREADS-1:0] thr_halt,
    input  logic [NUM_THREADS-1:0] thr_active,
    input  logic [CNT_W-1:0]       cfg_count,
    output logic [NUM_THREADS-1:0] halt_req,
    output logic [NUM_THREADS-1:0] resume_req,
    output logic                   sweep_done
);
    localparam int IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
    localparam logic [CNT_W-1:0] TOP_CNT = CNT_W'(NUM_THREADS - 1);

    logic             expired;
    logic             timer_load;
    logic             timer_run;
    logic             sweep_en;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = (cfg_count >= TOP_CNT) ? IDX_W'(NUM_THREADS - 1)
                                             : IDX_W'(cfg_count);

    thr_delay_timer #(.DELAY(DELAY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .run     (timer_run),
        .expired (expired)
    );

    thr_sweep_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (wr_strobe),
        .expired    (expired),
        .last_idx   (last_idx),
        .timer_load (timer_load),
        .timer_run  (timer_run),
        .sweep_en   (sweep_en),
        .idx        (idx),
        .sweep_done (sweep_done)
    );

    thr_verdict #(.NUM_THREADS(NUM_THREADS), .IDX_W(IDX_W)) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sweep_en),
        .idx        (idx),
        .thr_halt   (thr_halt),
        .thr_active (thr_active),
        .halt_req   (halt_req),
        .resume_req (resume_req)
    );

    assert_no_pulse_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> ((halt_req | resume_req) == '0));
endmodule

// File: tb/test_thread_runstate_sched.sv
module test_thread_runstate_sched;
    localparam int NT  = 4;
    localparam int DLY = 2;
    localparam int WIN = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_strobe = 1'b0;
    logic [NT-1:0] thr_halt = '0;
    logic [NT-1:0] thr_active = '0;
    logic [7:0]    cfg_count = 8'd3;
    logic [NT-1:0] halt_req;
    logic [NT-1:0] resume_req;
    logic          sweep_done;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    thread_runstate_sched #(.NUM_THREADS(NT), .DELAY(DLY), .CNT_W(8)) i_thread_runstate_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (wr_strobe),
        .thr_halt   (thr_halt),
        .thr_active (thr_active),
        .cfg_count  (cfg_count),
        .halt_req   (halt_req),
        .resume_req (resume_req),
        .sweep_done (sweep_done)
    );

    // Each entry packs halt, active, count, expected halt, expected resume, visited.
    localparam logic [27:0] VEC [7] = '{
        {4'b0000, 4'b1111, 8'd3,   4'b0000, 4'b1111, 4'd4},
        {4'b1111, 4'b1111, 8'd3,   4'b1111, 4'b0000, 4'd4},
        {4'b0000, 4'b0000, 8'd3,   4'b1111, 4'b0000, 4'd4},
        {4'b0101, 4'b0011, 8'd3,   4'b1101, 4'b0010, 4'd4},
        {4'b0101, 4'b0011, 8'd1,   4'b0001, 4'b0010, 4'd2},
        {4'b0000, 4'b1111, 8'd0,   4'b0000, 4'b0001, 4'd1},
        {4'b1000, 4'b1111, 8'd200, 4'b1000, 4'b0111, 4'd4}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Raise the strobe, then observe WIN samples. Extra strobes are placed at the
    // sample indices set in strobe_mask. k counts samples after the strobe edge.
    task automatic run_sweep(input logic [WIN-1:0] strobe_mask,
                             output logic [NT-1:0] seen_h, output logic [NT-1:0] seen_r,
                             output int first_k, output int n_done, output int last_done,
                             output int bad_cycles, output int late_k);
        int hits [NT];
        seen_h = '0; seen_r = '0; first_k = -1; n_done = 0; last_done = -1;
        bad_cycles = 0; late_k = -1;
        for (int t = 0; t < NT; t++) hits[t] = 0;
        @(negedge clk);
        wr_strobe = 1'b1;
        @(negedge clk);
        for (int k = 0; k < WIN; k++) begin
            seen_h |= halt_req;
            seen_r |= resume_req;
            if ((halt_req | resume_req) != '0) begin
                if (first_k < 0) first_k = k;
                late_k = k;
            end
            if ((halt_req & resume_req) != '0 || $countones(halt_req | resume_req) > 1)
                bad_cycles++;
            for (int t = 0; t < NT; t++)
                if (halt_req[t] || resume_req[t]) hits[t]++;
            if (sweep_done) begin
                n_done++;
                last_done = k;
            end
            wr_strobe = strobe_mask[k];
            @(negedge clk);
        end
        wr_strobe = 1'b0;
        for (int t = 0; t < NT; t++) if (hits[t] > 1 && n_done < 2) bad_cycles++;
    endtask

    initial begin
        #(20 * 100000);
        if (!ended) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NT-1:0] sh, sr;
        int fk, nd, ld, bad, lk;

        repeat (3) @(negedge clk);
        check(halt_req == '0 && resume_req == '0 && !sweep_done, "R1", "outputs in reset",
              int'({halt_req, resume_req, sweep_done}), 0);
        rst_n = 1'b1;
        begin
            int busy = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (halt_req != '0 || resume_req != '0 || sweep_done) busy++;
            end
            check(busy == 0, "R1", "idle pulses without strobe", busy, 0);
        end

        for (int v = 0; v < 7; v++) begin
            logic [27:0] e;
            e = VEC[v];
            thr_halt   = e[27:24];
            thr_active = e[23:20];
            cfg_count  = e[19:12];
            run_sweep('0, sh, sr, fk, nd, ld, bad, lk);
            check(sh == e[11:8], "R5 R10", $sformatf("vec%0d halt mask", v), sh, e[11:8]);
            check(sr == e[7:4], "R6 R10", $sformatf("vec%0d resume mask", v), sr, e[7:4]);
            check(ld == DLY + int'(e[3:0]) && nd == 1, "R4 R8",
                  $sformatf("vec%0d done sample", v), ld, DLY + int'(e[3:0]));
            check(fk == DLY && lk == DLY + int'(e[3:0]) - 1, "R2", $sformatf("vec%0d first pulse", v),
                  fk, DLY);
            check(bad == 0, "R7", $sformatf("vec%0d exclusive pulses", v), bad, 0);
        end

        // Coalescing: extra strobes during the wait and during the sweep.
        thr_halt = 4'b0011; thr_active = 4'b1111; cfg_count = 8'd3;
        run_sweep(WIN'(32'b1010), sh, sr, fk, nd, ld, bad, lk);
        check(nd == 1, "R3", "sweeps after burst", nd, 1);
        check(ld == DLY + NT && fk == DLY, "R3", "burst done sample", ld, DLY + NT);
        check(sh == 4'b0011 && sr == 4'b1100 && bad == 0, "R3", "burst masks",
              int'({sh, sr}), int'({4'b0011, 4'b1100}));

        // Re-arm: strobe exactly in the done cycle (sample DLY+NT).
        run_sweep(WIN'(1) << (DLY + NT), sh, sr, fk, nd, ld, bad, lk);
        check(nd == 2, "R9", "sweeps after done-cycle strobe", nd, 2);
        check(ld == 2 * (DLY + NT) + 1, "R9", "second done sample", ld, 2 * (DLY + NT) + 1);

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule